// File: doc/BRIEF.md
# Custom-Instruction Overlay with Configuration Loader

This block is a small fine-grained programmable fabric attached beside a processor core to run custom instructions, together with the loader that fills its configuration. The fabric has four clusters. Each cluster is fed one byte of each of the two 32-bit operands and drives one byte of the 32-bit result. Inside a cluster sit eight logic cells. Each cell holds two 4-input lookup tables that share one set of inputs, plus one user flip-flop. Sparse selectors pick each table input, each result bit and each signal passed to a neighbouring cluster.

The whole behaviour of the fabric is fixed by a 1696-bit configuration image. The host pulses a start input and then presents the image as columns of `NCHAIN` bits, one column per shift cycle, to parallel shift chains. One, eight or thirty-two chains give 1696, 212 or 53 shift cycles. While the loader is busy, no custom-instruction result is produced. A programmable wait count stretches the latency of every instruction, so a slow configured function can settle while the core keeps its full clock rate. An instruction takes either two register operands or a register and a 16-bit immediate.

Top module: `ovl_ci_top`

## Requirements
- R1: After synchronous reset, cfg_busy, cfg_done and ci_res_valid are 0, ci_res is 0, the wait count is 0, every image bit, cell flip-flop and link register is 0, and an instruction then returns 0.
- R2: A cfg_start pulse while cfg_busy is 0 sets cfg_busy and clears cfg_done from the next cycle, and clears all cell flip-flops and link registers. While cfg_busy is 0, cfg_valid and cfg_data have no effect on the image.
- R3: With L = 1696/NCHAIN, each cycle with cfg_busy and cfg_valid both 1 is one shift. Cycles with cfg_valid at 0 are not counted. At the edge of shift number L, cfg_busy falls and cfg_done rises. In shift s (starting from 0), cfg_data[j] becomes image bit j*L+s.
- R4: A cfg_start pulse while cfg_busy is 1 is ignored, and the load still completes after exactly L shifts.
- R5: Image layout for cluster i, cell c, table l, input k, result bit j and link t. The table bits are at 256i+32c+16l+addr. Here addr is the 4-bit input word, with input 0 as its LSB. The cell output select is at 1024+8i+c. Input select k is 3 bits, LSB first, at 1056+96i+12c+3k. Result select j is 2 bits at 1440+16i+2j. Link select t is 2 bits at 1504+48i+2t. Table 0 of a cell drives its primary output; table 1 drives its secondary output.
- R6: Input k of cell c uses idx=(c+k) mod 8. Code 0 picks A byte bit idx. Code 1 picks B byte bit idx. Code 2 picks A byte bit (idx+4) mod 8. Code 3 picks this cluster's flip-flop idx. Codes 4, 5 and 6 pick incoming link bit idx, 8+idx and 16+idx. Code 7 gives 0.
- R7: Cell output select 0 passes table 0 combinationally; select 1 passes the cell flip-flop. Every flip-flop loads its table-0 value at each retire edge and holds otherwise.
- R8: Result select for bit j: 0 gives the primary output of cell j, 1 the secondary output of cell j, 2 the primary output of cell (j+4) mod 8, and 3 the secondary output of cell (j+4) mod 8. Link t is registered at each retire edge. Its select gives 0 for the primary output of cell t mod 8, 1 for the secondary output, 2 for flip-flop t mod 8, and 3 for A byte bit t mod 8. Link group g (bits 8g..8g+7) of cluster i arrives at cluster (i+g+1) mod 4 on the same bit positions.
- R9: With ci_imm_form=1, operand B is ci_imm sign-extended to 32 bits and ci_op_b is ignored.
- R10: ws_we writes ws_data into the wait count W. An instruction accepted at edge e uses the W held before e. Its result appears with a one-cycle ci_res_valid pulse from edge e+1+W. ci_res holds its value between results.
- R11: ci_issue is accepted only while cfg_busy is 0, no instruction is pending, and no start is accepted at the same edge. A start accepted while an instruction is pending, including at its retire edge, discards it, and no ci_res_valid follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 1 | Begin a configuration load |
| cfg_valid | input | 1 | cfg_data column is present this cycle |
| cfg_data | input | NCHAIN | One image bit per chain |
| cfg_busy | output | 1 | Load in progress |
| cfg_done | output | 1 | Last load completed |
| ws_we | input | 1 | Write the wait count |
| ws_data | input | WS_W | New wait count |
| ci_issue | input | 1 | Issue a custom instruction |
| ci_imm_form | input | 1 | Operand B from the immediate |
| ci_op_a | input | 32 | Operand A |
| ci_op_b | input | 32 | Operand B (register form) |
| ci_imm | input | 16 | Immediate (immediate form) |
| ci_res_valid | output | 1 | Result pulse |
| ci_res | output | 32 | Result of the last retired instruction |

## Verification
The delicate case is a new load starting at the very edge where a pending instruction would retire. The bench pulses cfg_start so that it is sampled exactly at the retire edge of an instruction with a zero wait count. It then requires ci_res_valid to stay low and cfg_busy to rise. A second overlap is an issue and a repeated start presented during an active load. Here the bench expects no result and expects the load to finish after exactly L counted shifts. A behavioural model steps every clock and compares the busy, done and valid outputs, and the result whenever it is valid, across pseudo-random images, operands and wait counts.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
    localparam int N_CLU    = 4;
    localparam int N_CELL   = 8;
    localparam int LUT_K    = 4;
    localparam int LUT_SZ   = 1 << LUT_K;
    localparam int SEL_W    = 3;
    localparam int RSEL_W   = 2;
    localparam int XGRP     = N_CLU - 1;
    localparam int XSIG     = XGRP * N_CELL;

    localparam int CL_LUT   = N_CELL * 2 * LUT_SZ;
    localparam int CL_OSEL  = N_CELL;
    localparam int CL_ISEL  = N_CELL * LUT_K * SEL_W;
    localparam int CL_RSEL  = N_CELL * RSEL_W;
    localparam int CL_XSEL  = XSIG * RSEL_W;

    localparam int OFF_LUT  = 0;
    localparam int OFF_OSEL = OFF_LUT  + N_CLU * CL_LUT;
    localparam int OFF_ISEL = OFF_OSEL + N_CLU * CL_OSEL;
    localparam int OFF_RSEL = OFF_ISEL + N_CLU * CL_ISEL;
    localparam int OFF_XSEL = OFF_RSEL + N_CLU * CL_RSEL;
    localparam int CFG_BITS = OFF_XSEL + N_CLU * CL_XSEL;

    typedef enum logic [SEL_W-1:0] {
        SRC_A, SRC_B, SRC_AFAR, SRC_Q, SRC_X0, SRC_X1, SRC_X2, SRC_ZERO
    } lin_src_e;

    typedef enum logic [RSEL_W-1:0] {
        RES_P, RES_S, RES_PFAR, RES_SFAR
    } res_src_e;

    typedef enum logic [RSEL_W-1:0] {
        LNK_P, LNK_S, LNK_Q, LNK_A
    } lnk_src_e;

    typedef struct packed {
        logic [CL_XSEL-1:0] xsel;
        logic [CL_RSEL-1:0] rsel;
        logic [CL_ISEL-1:0] isel;
        logic [CL_OSEL-1:0] osel;
        logic [CL_LUT-1:0]  lut;
    } clu_cfg_t;

    typedef struct packed {
        logic [N_CELL-1:0] a;
        logic [N_CELL-1:0] b;
    } byte_pair_t;

    function automatic clu_cfg_t pick_cfg(input logic [CFG_BITS-1:0] img, input int i);
        clu_cfg_t r;
        r.lut  = img[OFF_LUT  + i*CL_LUT  +: CL_LUT];
        r.osel = img[OFF_OSEL + i*CL_OSEL +: CL_OSEL];
        r.isel = img[OFF_ISEL + i*CL_ISEL +: CL_ISEL];
        r.rsel = img[OFF_RSEL + i*CL_RSEL +: CL_RSEL];
        r.xsel = img[OFF_XSEL + i*CL_XSEL +: CL_XSEL];
        return r;
    endfunction

    function automatic logic [31:0] sext16(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction
endpackage

// File: rtl/ovl_loader.sv
module ovl_loader
    import ovl_pkg::*;
#(
    parameter int NCHAIN = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                valid,
    input  logic [NCHAIN-1:0]   data,
    output logic                busy,
    output logic                done,
    output logic                start_acc,
    output logic [CFG_BITS-1:0] img
);
    localparam int LEN = CFG_BITS / NCHAIN;
    localparam int CW  = $clog2(LEN + 1);

    logic          shift;
    logic          last;
    logic [CW-1:0] cnt;

    assign start_acc = start && !busy;
    assign shift     = busy && valid;
    assign last      = shift && (cnt == CW'(LEN - 1));

    for (genvar j = 0; j < NCHAIN; j++) begin : g_chain
        logic [LEN-1:0] sr;
        always_ff @(posedge clk) begin
            if (rst)        sr <= '0;
            else if (shift) sr <= {data[j], sr[LEN-1:1]};
        end
        assign img[j*LEN +: LEN] = sr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
        end else if (start_acc) begin
            busy <= 1'b1;
            done <= 1'b0;
            cnt  <= '0;
        end else if (shift) begin
            if (last) begin
                busy <= 1'b0;
                done <= 1'b1;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R3: counter never passes the chain length
    a_r3_cnt_range: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt < CW'(LEN)));
    // R3: done only rises at the end of a busy period
    a_r3_done_after_load: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(busy));
    // R4: busy persists until the final shift, start pulses notwithstanding
    a_r4_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> busy);
    // R2: the image only changes on a counted shift
    a_r2_img_static: assert property (@(posedge clk) disable iff (rst)
        !(busy && valid) |=> $stable(img));
endmodule

// File: rtl/ovl_cluster.sv
module ovl_cluster
    import ovl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             upd,
    input  clu_cfg_t         cfg,
    input  byte_pair_t       opnd,
    input  logic [XSIG-1:0]  xin,
    output logic [N_CELL-1:0] res,
    output logic [XSIG-1:0]  xout
);
    logic [N_CELL-1:0] q, lut0, lut1, prim, sec;
    logic [XSIG-1:0]   xnext, xq;

    for (genvar c = 0; c < N_CELL; c++) begin : g_cell
        logic [LUT_K-1:0]  addr;
        logic [LUT_SZ-1:0] t0, t1;
        for (genvar k = 0; k < LUT_K; k++) begin : g_in
            localparam int IDX = (c + k) % N_CELL;
            lin_src_e sel;
            logic     v;
            assign sel = lin_src_e'(cfg.isel[(c*LUT_K + k)*SEL_W +: SEL_W]);
            always_comb begin
                case (sel)
                    SRC_A:    v = opnd.a[IDX];
                    SRC_B:    v = opnd.b[IDX];
                    SRC_AFAR: v = opnd.a[(IDX + N_CELL/2) % N_CELL];
                    SRC_Q:    v = q[IDX];
                    SRC_X0:   v = xin[IDX];
                    SRC_X1:   v = xin[N_CELL + IDX];
                    SRC_X2:   v = xin[2*N_CELL + IDX];
                    default:  v = 1'b0;
                endcase
            end
            assign addr[k] = v;
        end
        assign t0      = cfg.lut[(2*c)*LUT_SZ +: LUT_SZ];
        assign t1      = cfg.lut[(2*c+1)*LUT_SZ +: LUT_SZ];
        assign lut0[c] = t0[addr];
        assign lut1[c] = t1[addr];
        assign prim[c] = cfg.osel[c] ? q[c] : lut0[c];
        assign sec[c]  = lut1[c];
    end

    for (genvar j = 0; j < N_CELL; j++) begin : g_res
        localparam int FAR = (j + N_CELL/2) % N_CELL;
        res_src_e rs;
        assign rs = res_src_e'(cfg.rsel[j*RSEL_W +: RSEL_W]);
        always_comb begin
            case (rs)
                RES_P:    res[j] = prim[j];
                RES_S:    res[j] = sec[j];
                RES_PFAR: res[j] = prim[FAR];
                default:  res[j] = sec[FAR];
            endcase
        end
    end

    for (genvar t = 0; t < XSIG; t++) begin : g_lnk
        localparam int C = t % N_CELL;
        lnk_src_e ls;
        assign ls = lnk_src_e'(cfg.xsel[t*RSEL_W +: RSEL_W]);
        always_comb begin
            case (ls)
                LNK_P:   xnext[t] = prim[C];
                LNK_S:   xnext[t] = sec[C];
                LNK_Q:   xnext[t] = q[C];
                default: xnext[t] = opnd.a[C];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q  <= '0;
            xq <= '0;
        end else if (upd) begin
            q  <= lut0;
            xq <= xnext;
        end
    end
    assign xout = xq;

    // R7: cell flip-flops change only on retire or clear
    a_r7_q_hold: assert property (@(posedge clk) disable iff (rst)
        !(upd || clr) |=> $stable(q));
    // R8: link registers change only on retire or clear
    a_r8_link_hold: assert property (@(posedge clk) disable iff (rst)
        !(upd || clr) |=> $stable(xout));
endmodule

// File: rtl/ovl_seq.sv
module ovl_seq #(
    parameter int WS_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            issue,
    input  logic            busy,
    input  logic            start_acc,
    input  logic            ws_we,
    input  logic [WS_W-1:0] ws_data,
    output logic            accept,
    output logic            retire,
    output logic            res_valid
);
    logic            pending;
    logic [WS_W-1:0] wcnt, wreg;

    assign accept = issue && !busy && !pending && !start_acc;
    assign retire = pending && (wcnt == '0) && !start_acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending   <= 1'b0;
            wcnt      <= '0;
            wreg      <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= retire;
            if (ws_we) wreg <= ws_data;
            if (start_acc) begin
                pending <= 1'b0;
            end else if (accept) begin
                pending <= 1'b1;
                wcnt    <= wreg;
            end else if (pending) begin
                if (wcnt == '0) pending <= 1'b0;
                else            wcnt    <= wcnt - 1'b1;
            end
        end
    end

    // R11: no result is reported while a load runs
    a_r11_valid_not_loading: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !busy);
    // R11: loading and a pending instruction never overlap
    a_r11_busy_no_pending: assert property (@(posedge clk) disable iff (rst)
        busy |-> !pending);
    // R10: an accepted instruction is pending on the next cycle
    a_r10_accept_pends: assert property (@(posedge clk) disable iff (rst)
        accept |=> pending);
    // R10: the result strobe lasts exactly one cycle
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);
endmodule

// File: rtl/ovl_ci_top.sv
module ovl_ci_top
    import ovl_pkg::*;
#(
    parameter int NCHAIN = 8,
    parameter int WS_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_start,
    input  logic              cfg_valid,
    input  logic [NCHAIN-1:0] cfg_data,
    output logic              cfg_busy,
    output logic              cfg_done,
    input  logic              ws_we,
    input  logic [WS_W-1:0]   ws_data,
    input  logic              ci_issue,
    input  logic              ci_imm_form,
    input  logic [31:0]       ci_op_a,
    input  logic [31:0]       ci_op_b,
    input  logic [15:0]       ci_imm,
    output logic              ci_res_valid,
    output logic [31:0]       ci_res
);
    logic [CFG_BITS-1:0] img;
    logic                start_acc, accept, retire;
    logic [31:0]         opa_q, opb_q, res_all;
    logic [N_CELL-1:0]   res_c [N_CLU];
    logic [XSIG-1:0]     xout  [N_CLU];
    logic [XSIG-1:0]     xin   [N_CLU];

    ovl_loader #(.NCHAIN(NCHAIN)) i_loader (
        .clk(clk), .rst(rst), .start(cfg_start), .valid(cfg_valid),
        .data(cfg_data), .busy(cfg_busy), .done(cfg_done),
        .start_acc(start_acc), .img(img)
    );

    ovl_seq #(.WS_W(WS_W)) i_seq (
        .clk(clk), .rst(rst), .issue(ci_issue), .busy(cfg_busy),
        .start_acc(start_acc), .ws_we(ws_we), .ws_data(ws_data),
        .accept(accept), .retire(retire), .res_valid(ci_res_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            opa_q  <= '0;
            opb_q  <= '0;
            ci_res <= '0;
        end else begin
            if (accept) begin
                opa_q <= ci_op_a;
                opb_q <= ci_imm_form ? sext16(ci_imm) : ci_op_b;
            end
            if (retire) ci_res <= res_all;
        end
    end

    for (genvar i = 0; i < N_CLU; i++) begin : g_clu
        byte_pair_t op;
        assign op.a = opa_q[i*N_CELL +: N_CELL];
        assign op.b = opb_q[i*N_CELL +: N_CELL];
        for (genvar g = 0; g < XGRP; g++) begin : g_link
            assign xin[i][g*N_CELL +: N_CELL] = xout[(i + N_CLU - 1 - g) % N_CLU][g*N_CELL +: N_CELL];
        end
        ovl_cluster i_cluster (
            .clk(clk), .rst(rst), .clr(start_acc), .upd(retire),
            .cfg(pick_cfg(img, i)), .opnd(op), .xin(xin[i]),
            .res(res_c[i]), .xout(xout[i])
        );
        assign res_all[i*N_CELL +: N_CELL] = res_c[i];
    end
endmodule

// File: tb/test_ovl_ci_top.sv
`timescale 1ns/1ps
module test_ovl_ci_top;
    localparam int NCH = 8;
    localparam int IMG = 1696;
    localparam int L   = IMG / NCH;

    logic clk = 1'b0, rst = 1'b1;
    logic cfg_start = 0, cfg_valid = 0, ws_we = 0, ci_issue = 0, ci_imm_form = 0;
    logic [NCH-1:0] cfg_data = '0;
    logic [3:0]  ws_data = '0;
    logic [31:0] ci_op_a = '0, ci_op_b = '0;
    logic [15:0] ci_imm = '0;
    logic cfg_busy, cfg_done, ci_res_valid;
    logic [31:0] ci_res;

    int checks = 0, errors = 0, cyc = 0;

    ovl_ci_top #(.NCHAIN(NCH), .WS_W(4)) i_ovl_ci_top (
        .clk(clk), .rst(rst), .cfg_start(cfg_start), .cfg_valid(cfg_valid),
        .cfg_data(cfg_data), .cfg_busy(cfg_busy), .cfg_done(cfg_done),
        .ws_we(ws_we), .ws_data(ws_data), .ci_issue(ci_issue),
        .ci_imm_form(ci_imm_form), .ci_op_a(ci_op_a), .ci_op_b(ci_op_b),
        .ci_imm(ci_imm), .ci_res_valid(ci_res_valid), .ci_res(ci_res)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit mimg [IMG];
    bit img_w [IMG];
    bit mq [4][8];
    bit mx [4][24];
    bit e_l0 [4][8];
    bit e_xn [4][24];
    bit m_busy, m_done, m_pend, m_rv;
    int m_cnt, m_wc;
    logic [3:0]  m_w;
    logic [31:0] m_a, m_b, m_res, e_res;

    function automatic int fld(int base, int n);
        int v = 0;
        for (int p = 0; p < n; p++) v |= int'(mimg[base + p]) << p;
        return v;
    endfunction

    function automatic void eval_model();
        bit o0 [8];
        bit o1 [8];
        for (int i = 0; i < 4; i++) begin
            for (int c = 0; c < 8; c++) begin
                int addr = 0;
                for (int k = 0; k < 4; k++) begin
                    int sel = fld(1056 + i*96 + c*12 + k*3, 3);
                    int idx = (c + k) % 8;
                    bit v;
                    case (sel)
                        0: v = m_a[8*i + idx];
                        1: v = m_b[8*i + idx];
                        2: v = m_a[8*i + (idx + 4) % 8];
                        3: v = mq[i][idx];
                        4: v = mx[(i + 3) % 4][idx];
                        5: v = mx[(i + 2) % 4][8 + idx];
                        6: v = mx[(i + 1) % 4][16 + idx];
                        default: v = 0;
                    endcase
                    addr |= int'(v) << k;
                end
                e_l0[i][c] = mimg[i*256 + c*32 + addr];
                o1[c]      = mimg[i*256 + c*32 + 16 + addr];
                o0[c]      = mimg[1024 + i*8 + c] ? mq[i][c] : e_l0[i][c];
            end
            for (int j = 0; j < 8; j++) begin
                case (fld(1440 + i*16 + 2*j, 2))
                    0: e_res[8*i + j] = o0[j];
                    1: e_res[8*i + j] = o1[j];
                    2: e_res[8*i + j] = o0[(j + 4) % 8];
                    default: e_res[8*i + j] = o1[(j + 4) % 8];
                endcase
            end
            for (int t = 0; t < 24; t++) begin
                case (fld(1504 + i*48 + 2*t, 2))
                    0: e_xn[i][t] = o0[t % 8];
                    1: e_xn[i][t] = o1[t % 8];
                    2: e_xn[i][t] = mq[i][t % 8];
                    default: e_xn[i][t] = m_a[8*i + t % 8];
                endcase
            end
        end
    endfunction

    always @(posedge clk) begin
        bit sacc, shf, acc, ret;
        if (rst) begin
            foreach (mimg[b]) mimg[b] = 0;
            foreach (mq[i, c]) mq[i][c] = 0;
            foreach (mx[i, t]) mx[i][t] = 0;
            m_busy = 0; m_done = 0; m_pend = 0; m_rv = 0;
            m_cnt = 0; m_wc = 0; m_w = 0; m_a = 0; m_b = 0; m_res = 0;
        end else begin
            sacc = cfg_start && !m_busy;
            shf  = m_busy && cfg_valid;
            acc  = ci_issue && !m_busy && !m_pend && !sacc;
            ret  = m_pend && m_wc == 0 && !sacc;
            m_rv = 0;
            if (ret) begin
                eval_model();
                mq = e_l0; mx = e_xn; m_res = e_res; m_rv = 1;
            end
            if (sacc) begin
                foreach (mq[i, c]) mq[i][c] = 0;
                foreach (mx[i, t]) mx[i][t] = 0;
                m_pend = 0;
            end else if (acc) begin
                m_pend = 1; m_wc = int'(m_w); m_a = ci_op_a;
                m_b = ci_imm_form ? {{16{ci_imm[15]}}, ci_imm} : ci_op_b;
            end else if (m_pend) begin
                if (m_wc == 0) m_pend = 0; else m_wc--;
            end
            if (ws_we) m_w = ws_data;
            if (sacc) begin
                m_busy = 1; m_done = 0; m_cnt = 0;
            end else if (shf) begin
                for (int j = 0; j < NCH; j++) begin
                    for (int p = 0; p < L - 1; p++) mimg[j*L + p] = mimg[j*L + p + 1];
                    mimg[j*L + L - 1] = cfg_data[j];
                end
                if (m_cnt == L - 1) begin m_busy = 0; m_done = 1; m_cnt = 0; end
                else m_cnt++;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            check(cfg_busy == m_busy, "R3 busy", 32'(cfg_busy), 32'(m_busy));
            check(cfg_done == m_done, "R3 done", 32'(cfg_done), 32'(m_done));
            check(ci_res_valid == m_rv, "R10 valid", 32'(ci_res_valid), 32'(m_rv));
            if (m_rv) check(ci_res == m_res, "R5 R6 R7 R8 result", ci_res, m_res);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic void put(int base, int n, int v);
        for (int p = 0; p < n; p++) img_w[base + p] = bit'((v >> p) & 1);
    endfunction

    function automatic void make_direct(int rs, bit os);
        foreach (img_w[b]) img_w[b] = 0;
        for (int i = 0; i < 4; i++)
            for (int c = 0; c < 8; c++) begin
                put(1056 + i*96 + c*12 + 0, 3, 0);
                put(1056 + i*96 + c*12 + 3, 3, 1);
                put(1056 + i*96 + c*12 + 6, 3, 7);
                put(1056 + i*96 + c*12 + 9, 3, 7);
                put(i*256 + c*32, 16, 16'hAAAA);
                put(i*256 + c*32 + 16, 16, 16'hCCCC);
                img_w[1024 + i*8 + c] = os;
                put(1440 + i*16 + 2*c, 2, rs);
            end
    endfunction

    function automatic void make_random();
        foreach (img_w[b]) img_w[b] = bit'($urandom & 1);
    endfunction

    function automatic logic [31:0] rotb(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[8*i +: 8] = {v[8*i], v[8*i+1 +: 7]};
        return r;
    endfunction

    task automatic pulse_start();
        cfg_start = 1; @(negedge clk); cfg_start = 0;
    endtask

    task automatic feed(input int gap, input bit mid);
        for (int s = 0; s < L; s++) begin
            if (gap > 0 && s % gap == 0) begin cfg_valid = 0; @(negedge clk); end
            for (int j = 0; j < NCH; j++) cfg_data[j] = img_w[j*L + s];
            cfg_valid = 1;
            if (mid && s == L/2) begin cfg_start = 1; ci_issue = 1; end
            if (s == L - 1) begin
                check(cfg_busy && !cfg_done, "R3 busy before last shift", {cfg_busy, cfg_done}, 32'd2);
            end
            @(negedge clk);
            cfg_start = 0; ci_issue = 0;
        end
        cfg_valid = 0;
        check(!cfg_busy && cfg_done, "R3 R4 done after L shifts", {cfg_busy, cfg_done}, 32'd1);
    endtask

    task automatic load(input int gap, input bit mid);
        pulse_start();
        feed(gap, mid);
    endtask

    task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic [15:0] im, input bit form);
        ci_op_a = a; ci_op_b = b; ci_imm = im; ci_imm_form = form; ci_issue = 1;
        @(negedge clk);
        ci_issue = 0;
    endtask

    task automatic run_ci(input logic [31:0] a, input logic [31:0] b, input logic [15:0] im,
                          input bit form, input int w, output logic [31:0] r);
        issue(a, b, im, form);
        repeat (w) @(negedge clk);
        @(negedge clk);
        check(ci_res_valid == 1'b1, "R10 latency", 32'(ci_res_valid), 32'd1);
        r = ci_res;
    endtask

    task automatic set_wait(input int w);
        ws_data = 4'(w); ws_we = 1; @(negedge clk); ws_we = 0;
    endtask

    initial begin
        logic [31:0] r;
        void'($urandom(7));
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        check(!cfg_busy && !cfg_done && !ci_res_valid, "R1 reset flags",
              {cfg_busy, cfg_done, ci_res_valid}, 32'd0);
        check(ci_res == 0, "R1 reset result", ci_res, 32'd0);
        run_ci(32'hDEADBEEF, 32'h12345678, 16'h0, 0, 0, r);
        check(r == 0, "R1 cleared image", r, 32'd0);

        // R5 R6: primary output mirrors operand A; R4 and R11 mid-load stimulus
        make_direct(0, 0);
        load(0, 1);
        run_ci(32'h1234_5678, 32'h0, 16'h0, 0, 0, r);
        check(r == 32'h1234_5678, "R6 input code 0 through table 0", r, 32'h1234_5678);

        // R2: column data while idle is ignored
        cfg_data = '1; cfg_valid = 1;
        repeat (3) @(negedge clk);
        cfg_valid = 0;
        run_ci(32'hA5C3_0F96, 32'h0, 16'h0, 0, 0, r);
        check(r == 32'hA5C3_0F96, "R2 idle columns ignored", r, 32'hA5C3_0F96);

        // R9 and R6: secondary output, operand B code 1, loaded with gaps
        make_direct(1, 0);
        load(5, 0);
        run_ci(32'h0, 32'h0F0F_3C3C, 16'h0, 0, 0, r);
        check(r == rotb(32'h0F0F_3C3C), "R6 input code 1 register form", r, rotb(32'h0F0F_3C3C));
        run_ci(32'h0, 32'hFFFF_FFFF, 16'h8421, 1, 0, r);
        check(r == rotb(32'hFFFF_8421), "R9 immediate sign extended", r, rotb(32'hFFFF_8421));
        run_ci(32'h0, 32'h0, 16'h0421, 1, 0, r);
        check(r == rotb(32'h0000_0421), "R9 immediate positive", r, rotb(32'h0000_0421));

        // R7: flip-flop output path
        make_direct(0, 1);
        load(0, 0);
        run_ci(32'h1111_2222, 32'h0, 16'h0, 0, 0, r);
        check(r == 0, "R7 flops cleared by load", r, 32'd0);
        run_ci(32'h3333_4444, 32'h0, 16'h0, 0, 0, r);
        check(r == 32'h1111_2222, "R7 flop holds previous table 0", r, 32'h1111_2222);

        // R10: wait count stretches latency; R11: issue while pending ignored
        set_wait(3);
        issue(32'h5555_6666, 32'h0, 16'h0, 0);
        for (int n = 0; n < 3; n++) begin
            if (n == 1) begin ci_op_a = 32'h7777_8888; ci_issue = 1; end
            @(negedge clk);
            ci_issue = 0;
            check(!ci_res_valid, "R10 no early result", 32'(ci_res_valid), 32'd0);
        end
        @(negedge clk);
        check(ci_res_valid == 1'b1, "R10 result after 1+W", 32'(ci_res_valid), 32'd1);
        check(ci_res == 32'h3333_4444, "R11 pending issue ignored", ci_res, 32'h3333_4444);
        @(negedge clk);
        check(!ci_res_valid, "R11 single result", 32'(ci_res_valid), 32'd0);
        set_wait(0);

        // R11: start lands on the retire edge
        issue(32'h9999_AAAA, 32'h0, 16'h0, 0);
        pulse_start();
        check(!ci_res_valid && cfg_busy, "R11 start on retire edge", {ci_res_valid, cfg_busy}, 32'd1);
        make_random();
        feed(0, 0);

        // R8 and the rest: random images, operands and wait counts
        for (int m = 0; m < 6; m++) begin
            make_random();
            load(m, m % 2 == 1);
            for (int n = 0; n < 12; n++) begin
                int w = n % 3;
                set_wait(w);
                run_ci($urandom, $urandom, 16'($urandom), bit'(n % 4 == 3), w, r);
            end
        end

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule